// File: doc/BRIEF.md
# Scan-Mode Multichannel Result Serializer

This block pushes converter results out of a serial data pin with no read command from the host. A per-channel enable mask selects which of the four 16-bit channel results take part. Each time a new result set arrives on the valid strobe, the block copies the results into a shadow buffer. It then drives its active-low end-of-conversion flag low and presents the enabled results one after another. The host shifts them out with the serial clock while chip select is low.

The serial clock and chip select are sampled in the system clock domain. A rising serial clock edge advances the output one system clock after it is sampled. The burst ends, and the flag goes high again, when the last bit has been clocked out. The burst is also cut short when the converter signals that the next result set is one cycle away. While any channel is enabled, host read requests are refused.

Top module: `scan_serializer`

## Requirements
- R1: After reset the flag `eoc_no` is high, `dout_o` is 0 and `rd_ack_o` is 0. `scan_en_i` bit k enables channel k, where bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R2: A burst sends the enabled channels in the order A, B, C, D and leaves out disabled channels with no gap. Each channel is sent as 16 bits, MSB first. Channel k's result is `results_i[16k+15:16k]`.
- R3: A valid strobe with a non-zero mask drives `eoc_no` low in the next cycle. A strobe with an all-zero mask leaves `eoc_no` high and `dout_o` at 0.
- R4: As soon as `eoc_no` is low, `dout_o` carries the MSB of the first enabled channel, before any serial clock edge.
- R5: `dout_o` moves to the next bit only after a rising edge of `sclk_i` while `cs_ni` is low. It changes one system clock after the edge is sampled and holds otherwise.
- R6: While `cs_ni` is high, `dout_o` is 0 and serial clock edges are ignored. The burst position is kept, so the burst resumes at the same bit when `cs_ni` returns low.
- R7: `eoc_no` returns high one cycle after the clock edge that shifts out the last bit of the last enabled channel.
- R8: A pulse on `res_early_i`, which means a result set will arrive in the next cycle, drives `eoc_no` high in the next cycle and abandons the burst.
- R9: A valid strobe that arrives during an unfinished burst restarts the burst at the first enabled channel, using the new data.
- R10: Serial clocks beyond the end of a burst leave `dout_o` at 0.
- R11: A change on `results_i` or `scan_en_i` without a strobe does not alter a burst in progress.
- R12: A read request on `rd_req_i` is acknowledged on `rd_ack_o` one cycle later only when `scan_en_i` is all zeros. While any enable bit is set, the request is ignored and `rd_ack_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 4 | Per-channel enable mask, bit 0 = A |
| res_valid_i | input | 1 | New result set valid strobe |
| res_early_i | input | 1 | Next result set arrives in the following cycle |
| results_i | input | 64 | Four 16-bit results, channel A in the low bits |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| rd_req_i | input | 1 | Host read request |
| dout_o | output | 1 | Serial data out |
| eoc_no | output | 1 | End-of-conversion flag, active low |
| rd_ack_o | output | 1 | Read request accepted |

## Verification
The assertions check on every cycle the rules that hold whatever the data is:
- the flag's reaction to a strobe, to a zero mask and to the early warning;
- the output being 0 whenever chip select or the flag is high;
- the output holding steady when no serial clock edge is sampled;
- refused reads while scan mode is on.

The channel order, skipped channels, MSB-first bit sequence, end-of-burst timing, resumption after a chip-select gap and restart on truncation all depend on the data values. Only the bench's scoreboard scenarios can show these.

// File: rtl/scan_ser_pkg.sv
package scan_ser_pkg;
  localparam int unsigned NUM_CH_DEF = 4;
  localparam int unsigned RES_W_DEF  = 16;
endpackage

// File: rtl/scan_sclk_edge.sv
module scan_sclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic rise_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  // edges seen while deselected are dropped
  assign rise_o = sclk_i & ~sclk_q & ~cs_ni;
endmodule

// File: rtl/scan_shadow.sv
module scan_shadow #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_W  = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               load_i,
  input  logic [NUM_CH-1:0]                  mask_i,
  input  logic [NUM_CH*RES_W-1:0]            data_i,
  output logic [NUM_CH-1:0]                  mask_o,
  output logic [NUM_CH-1:0][RES_W-1:0]       data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      data_o <= '0;
    end else if (load_i) begin
      mask_o <= mask_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int unsigned BIT_W  = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic              res_early_i,
  input  logic [NUM_CH-1:0] scan_en_i,
  input  logic [NUM_CH-1:0] mask_q_i,
  input  logic              rise_i,
  output logic              active_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              eoc_no
);
  logic              first_ok, nxt_ok;
  logic [CH_W-1:0]   first_idx, nxt_idx;

  // lowest enabled channel of the incoming mask
  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!first_ok && scan_en_i[i]) begin
        first_ok  = 1'b1;
        first_idx = CH_W'(i);
      end
    end
  end

  // next enabled channel above the current one, latched mask
  always_comb begin
    nxt_ok  = 1'b0;
    nxt_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!nxt_ok && mask_q_i[i] && (i > int'(ch_o))) begin
        nxt_ok  = 1'b1;
        nxt_idx = CH_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      ch_o     <= '0;
      bit_o    <= '0;
      eoc_no   <= 1'b1;
    end else if (res_valid_i) begin
      active_o <= first_ok;
      ch_o     <= first_idx;
      bit_o    <= BIT_W'(RES_W - 1);
      eoc_no   <= ~first_ok;
    end else if (res_early_i) begin
      active_o <= 1'b0;
      eoc_no   <= 1'b1;
    end else if (active_o && rise_i) begin
      if (bit_o == '0) begin
        if (nxt_ok) begin
          ch_o  <= nxt_idx;
          bit_o <= BIT_W'(RES_W - 1);
        end else begin
          active_o <= 1'b0;
          eoc_no   <= 1'b1;
        end
      end else begin
        bit_o <= bit_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_serializer.sv
module scan_serializer
  import scan_ser_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned RES_W  = RES_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       scan_en_i,
  input  logic                    res_valid_i,
  input  logic                    res_early_i,
  input  logic [NUM_CH*RES_W-1:0] results_i,
  input  logic                    cs_ni,
  input  logic                    sclk_i,
  input  logic                    rd_req_i,
  output logic                    dout_o,
  output logic                    eoc_no,
  output logic                    rd_ack_o
);
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned BIT_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic                         rise;
  logic                         active;
  logic [CH_W-1:0]              ch;
  logic [BIT_W-1:0]             bit_idx;
  logic [NUM_CH-1:0]            mask_q;
  logic [NUM_CH-1:0][RES_W-1:0] data_q;

  scan_sclk_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .cs_ni  (cs_ni),
    .rise_o (rise)
  );

  scan_shadow #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (res_valid_i),
    .mask_i (scan_en_i),
    .data_i (results_i),
    .mask_o (mask_q),
    .data_o (data_q)
  );

  scan_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W), .BIT_W(BIT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_valid_i (res_valid_i),
    .res_early_i (res_early_i),
    .scan_en_i   (scan_en_i),
    .mask_q_i    (mask_q),
    .rise_i      (rise),
    .active_o    (active),
    .ch_o        (ch),
    .bit_o       (bit_idx),
    .eoc_no      (eoc_no)
  );

  // current bit is visible with no serial edge needed
  assign dout_o = active & ~cs_ni & data_q[ch][bit_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ack_o <= 1'b0;
    else         rd_ack_o <= rd_req_i & ~(|scan_en_i);
  end
endmodule

// File: rtl/scan_serializer_chk.sv
module scan_serializer_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] scan_en_i,
  input logic              res_valid_i,
  input logic              res_early_i,
  input logic              cs_ni,
  input logic              sclk_i,
  input logic              rd_req_i,
  input logic              dout_o,
  input logic              eoc_no,
  input logic              rd_ack_o
);
  a_r3_eoc_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && |scan_en_i) |=> !eoc_no);

  a_r3_zero_mask_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && scan_en_i == '0) |=> (eoc_no && !dout_o));

  a_r8_early_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_early_i && !res_valid_i) |=> eoc_no);

  a_r6_cs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !dout_o);

  a_r10_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_no |-> !dout_o);

  a_r5_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && !res_early_i && !sclk_i && !cs_ni) |=> (cs_ni || $stable(dout_o)));

  a_r12_read_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && |scan_en_i) |=> !rd_ack_o);
endmodule

bind scan_serializer scan_serializer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_en_i   (scan_en_i),
  .res_valid_i (res_valid_i),
  .res_early_i (res_early_i),
  .cs_ni       (cs_ni),
  .sclk_i      (sclk_i),
  .rd_req_i    (rd_req_i),
  .dout_o      (dout_o),
  .eoc_no      (eoc_no),
  .rd_ack_o    (rd_ack_o)
);

// File: tb/scan_serializer_bench.sv
module scan_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  scan_en = '0;
  logic        res_valid = 1'b0;
  logic        res_early = 1'b0;
  logic [63:0] results = '0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        rd_req = 1'b0;
  logic        dout, eoc_n, rd_ack;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_q[$];

  always #4 clk = ~clk; // 125 MHz

  scan_serializer u_scan_serializer (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .res_valid_i(res_valid),
    .res_early_i(res_early), .results_i(results), .cs_ni(cs_n), .sclk_i(sclk),
    .rd_req_i(rd_req), .dout_o(dout), .eoc_no(eoc_n), .rd_ack_o(rd_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: strobe a result set and queue the expected stream
  task automatic send_set(input logic [3:0] m, input logic [63:0] d);
    @(negedge clk);
    scan_en = m; results = d; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    exp_q.delete();
    for (int k = 0; k < 4; k++)
      if (m[k])
        for (int b = 15; b >= 0; b--) exp_q.push_back(d[16*k + b]);
  endtask

  task automatic pulse();
    sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare the present bit with the queue head, then advance
  task automatic shift_bits(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      bit e;
      e = exp_q.pop_front();
      chk(dout == e, tag, int'(dout), int'(e));
      pulse();
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(eoc_n == 1'b1, "R1 eoc", int'(eoc_n), 1);
    chk(dout == 1'b0, "R1 dout", int'(dout), 0);
    chk(rd_ack == 1'b0, "R1 ack", int'(rd_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 read accepted with zero mask
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_ack == 1'b1, "R12 ack zero mask", int'(rd_ack), 1);

    // R3 zero mask strobe leaves flag high
    send_set(4'b0000, 64'hFFFF_FFFF_FFFF_FFFF);
    cs_n = 1'b0;
    @(negedge clk);
    chk(eoc_n == 1'b1, "R3 zero mask eoc", int'(eoc_n), 1);
    chk(dout == 1'b0, "R3 zero mask dout", int'(dout), 0);

    // R2 R4 R11 full burst, inputs scrambled after strobe
    send_set(4'b1111, 64'hA5C3_0F1E_8001_7FFE);
    chk(eoc_n == 1'b0, "R3 eoc falls", int'(eoc_n), 0);
    chk(dout == exp_q[0], "R4 first msb", int'(dout), int'(exp_q[0]));
    results = 64'h0123_4567_89AB_CDEF;
    scan_en = 4'b0001;
    shift_bits(63, "R2 R11 full stream");
    chk(eoc_n == 1'b0, "R7 eoc low before last", int'(eoc_n), 0);
    shift_bits(1, "R2 last bit");
    chk(eoc_n == 1'b1, "R7 eoc high after last", int'(eoc_n), 1);
    pulse();
    chk(dout == 1'b0, "R10 extra clock", int'(dout), 0);

    // R2 skip A and C
    send_set(4'b1010, 64'h8000_1234_FFFF_C001);
    chk(dout == exp_q[0], "R4 msb of B", int'(dout), int'(exp_q[0]));
    shift_bits(32, "R2 skip stream");
    chk(eoc_n == 1'b1, "R7 skip end", int'(eoc_n), 1);

    // R6 chip select gap between channels, R5 hold without edges
    send_set(4'b0011, 64'h0000_0000_B00F_6A5A);
    shift_bits(16, "R6 first channel");
    cs_n = 1'b1;
    @(negedge clk);
    chk(dout == 1'b0, "R6 cs high dout", int'(dout), 0);
    pulse();
    pulse();
    cs_n = 1'b0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(dout == exp_q[0], "R5 hold no edge", int'(dout), int'(exp_q[0]));
    shift_bits(16, "R6 resume stream");
    chk(eoc_n == 1'b1, "R7 after gap", int'(eoc_n), 1);

    // R9 truncated burst restarts with new data
    send_set(4'b0011, 64'h0000_0000_FFFF_FFFF);
    shift_bits(5, "R9 partial");
    send_set(4'b0011, 64'h0000_0000_1357_0000);
    chk(eoc_n == 1'b0, "R9 eoc low", int'(eoc_n), 0);
    chk(dout == 1'b0, "R9 restart msb", int'(dout), 0);
    shift_bits(32, "R9 restarted stream");
    chk(eoc_n == 1'b1, "R9 end", int'(eoc_n), 1);

    // R8 early warning ends the burst
    send_set(4'b1000, 64'hFFFF_0000_0000_0000);
    shift_bits(3, "R8 partial");
    res_early = 1'b1;
    @(negedge clk);
    res_early = 1'b0;
    chk(eoc_n == 1'b1, "R8 eoc high", int'(eoc_n), 1);
    chk(dout == 1'b0, "R8 dout low", int'(dout), 0);

    // R12 read ignored in scan mode
    scan_en = 4'b0100;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_ack == 1'b0, "R12 ack blocked", int'(rd_ack), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule